// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This purely combinational block decides where a 32-bit RISC core fetches next. It takes the address of the current instruction, the instruction word and the value of the one register the instruction names. It returns the next fetch address, a flag saying that control flow left the sequential path, and a request to write a return address into the link register, together with the value to write.

Two conditional branches compare the supplied register with zero. Two jumps move by a signed 26-bit distance from the sequential address. Two further jumps go to the address held in the register. One of each jump pair also asks for the return address to be saved. The caller reads the register file beforehand and steers the link write to register 31. Any other opcode continues with the sequential address.

Top module: `bjn_unit`

## Requirements
- R1: The opcode is bits [31:26] of the instruction word. For any opcode other than 010000, 010001, 001100, 001101, 001110 and 001111, the next PC is PC+4 and both the taken flag and the link write enable are low.
- R2: Opcode 010000 (branch on zero) with a register value of zero gives a next PC of PC+4 plus bits [15:0] sign-extended, with the taken flag high.
- R3: Opcode 010000 with a nonzero register value gives PC+4 with the taken flag low, whatever the offset field holds.
- R4: Opcode 010001 (branch on nonzero) is taken to PC+4 plus sign-extended bits [15:0] when the register is nonzero, and gives PC+4 with taken low when it is zero.
- R5: Opcode 001100 (relative jump) always gives PC+4 plus bits [25:0] sign-extended, with taken high and the link write enable low.
- R6: Opcode 001101 (relative jump with link) gives the same target as R5, with taken high, the link write enable high and a link value of PC+4.
- R7: Opcode 001110 (register jump) gives a next PC equal to the register value, with taken high and the link write enable low.
- R8: Opcode 001111 (register jump with link) gives a next PC equal to the register value, with taken high, the link write enable high and a link value of PC+4.
- R9: Offsets are byte counts that are added without scaling. All sums wrap modulo 2^32. This covers the most negative 16-bit and 26-bit offsets and a PC of 0xFFFFFFFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value of the register that is tested or used as the target |
| next_pc_o | output | 32 | Address to fetch next |
| taken_o | output | 1 | High when control leaves the sequential path |
| link_we_o | output | 1 | Request to write the return address to register 31 |
| link_val_o | output | 32 | Return address, PC+4 |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath, a 6-bit opcode, a 16-bit branch field and a 26-bit jump field. These widths put the most negative offsets of both fields within reach of single test vectors. They also make modular wraparound visible at both ends of the address space, for example at a PC of 0xFFFFFFFC and on a backward branch from a low address. Opcodes that differ by one bit from a control encoding are also applied, to show that decoding is exact.

// File: rtl/bjn_pkg.sv
package bjn_pkg;
  localparam logic [5:0] OPC_BRZ   = 6'b010000;
  localparam logic [5:0] OPC_BRNZ  = 6'b010001;
  localparam logic [5:0] OPC_JREL  = 6'b001100;
  localparam logic [5:0] OPC_JRELL = 6'b001101;
  localparam logic [5:0] OPC_JREG  = 6'b001110;
  localparam logic [5:0] OPC_JREGL = 6'b001111;

  typedef struct packed {
    logic br;       // conditional branch
    logic br_nz;    // branch wants nonzero
    logic jrel;     // pc-relative jump
    logic jreg;     // register jump
    logic link;     // save return address
  } ctl_cls_t;
endpackage

// File: rtl/bjn_decode.sv
module bjn_decode
  import bjn_pkg::*;
#(
  parameter int OPW = 6
) (
  input  logic [OPW-1:0] op_i,
  output ctl_cls_t       cls_o
);
  always_comb begin
    cls_o = '0;
    unique case (6'(op_i))
      OPC_BRZ:   cls_o.br = 1'b1;
      OPC_BRNZ:  begin cls_o.br = 1'b1; cls_o.br_nz = 1'b1; end
      OPC_JREL:  cls_o.jrel = 1'b1;
      OPC_JRELL: begin cls_o.jrel = 1'b1; cls_o.link = 1'b1; end
      OPC_JREG:  cls_o.jreg = 1'b1;
      OPC_JREGL: begin cls_o.jreg = 1'b1; cls_o.link = 1'b1; end
      default:   cls_o = '0;
    endcase
  end
endmodule

// File: rtl/bjn_cond.sv
module bjn_cond #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] val_i,
  input  logic            br_i,
  input  logic            br_nz_i,
  output logic            is_zero_o,
  output logic            cond_met_o
);
  assign is_zero_o  = (val_i == '0);
  assign cond_met_o = br_i & (br_nz_i ? ~is_zero_o : is_zero_o);
endmodule

// File: rtl/bjn_target.sv
module bjn_target
  import bjn_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int BOFF_W = 16,
  parameter int JOFF_W = 26,
  parameter int STEP   = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] reg_i,
  input  ctl_cls_t        cls_i,
  input  logic            cond_met_i,
  output logic [XLEN-1:0] seq_pc_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o
);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  function automatic logic [XLEN-1:0] sx_br(input logic [BOFF_W-1:0] f);
    return {{(XLEN-BOFF_W){f[BOFF_W-1]}}, f};
  endfunction

  function automatic logic [XLEN-1:0] sx_jmp(input logic [JOFF_W-1:0] f);
    return {{(XLEN-JOFF_W){f[JOFF_W-1]}}, f};
  endfunction

  logic [XLEN-1:0] br_tgt, jrel_tgt;

  assign seq_pc_o = pc_i + STEP_V;
  assign br_tgt   = seq_pc_o + sx_br(instr_i[BOFF_W-1:0]);
  assign jrel_tgt = seq_pc_o + sx_jmp(instr_i[JOFF_W-1:0]);

  always_comb begin
    next_pc_o = seq_pc_o;
    taken_o   = 1'b0;
    if (cls_i.jreg) begin
      next_pc_o = reg_i;
      taken_o   = 1'b1;
    end else if (cls_i.jrel) begin
      next_pc_o = jrel_tgt;
      taken_o   = 1'b1;
    end else if (cond_met_i) begin
      next_pc_o = br_tgt;
      taken_o   = 1'b1;
    end
  end
endmodule

// File: rtl/bjn_unit.sv
module bjn_unit
  import bjn_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int OPW    = 6,
  parameter int BOFF_W = 16,
  parameter int JOFF_W = 26
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] rs_val_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_val_o
);
  localparam int OP_LSB = XLEN - OPW;

  ctl_cls_t        cls;
  logic            is_zero;
  logic            cond_met;
  logic [XLEN-1:0] seq_pc;

  bjn_decode #(.OPW(OPW)) u_dec (
    .op_i  (instr_i[XLEN-1:OP_LSB]),
    .cls_o (cls)
  );

  bjn_cond #(.XLEN(XLEN)) u_cond (
    .val_i      (rs_val_i),
    .br_i       (cls.br),
    .br_nz_i    (cls.br_nz),
    .is_zero_o  (is_zero),
    .cond_met_o (cond_met)
  );

  bjn_target #(.XLEN(XLEN), .BOFF_W(BOFF_W), .JOFF_W(JOFF_W), .STEP(4)) u_tgt (
    .pc_i       (pc_i),
    .instr_i    (instr_i),
    .reg_i      (rs_val_i),
    .cls_i      (cls),
    .cond_met_i (cond_met),
    .seq_pc_o   (seq_pc),
    .next_pc_o  (next_pc_o),
    .taken_o    (taken_o)
  );

  assign link_we_o  = cls.link;
  assign link_val_o = seq_pc;
endmodule

// File: rtl/bjn_unit_chk.sv
module bjn_unit_chk #(
  parameter int XLEN = 32
) (
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] instr_i,
  input logic [XLEN-1:0] rs_val_i,
  input logic [XLEN-1:0] next_pc_o,
  input logic            taken_o,
  input logic            link_we_o,
  input logic [XLEN-1:0] link_val_o,
  input logic            br,
  input logic            jrel,
  input logic            jreg,
  input logic            is_zero,
  input logic            cond_met
);
  logic known;
  assign known = !$isunknown({pc_i, instr_i, rs_val_i});

  always_comb begin
    if (known) begin
      // R1 R3: staying on the sequential path means PC+4
      p_fallthrough_r1: assert (taken_o || next_pc_o == pc_i + XLEN'(4));
      // R1: nothing decoded means nothing taken or linked
      p_idle_r1: assert ((br || jrel || jreg) || (!taken_o && !link_we_o));
      // R4: a branch whose test fails is not taken
      p_brfail_r4: assert (!(br && !cond_met) || !taken_o);
      // R2: a zero test on a nonzero register never holds on the branch-on-zero path
      p_zerotest_r2: assert (!(br && cond_met && !is_zero) || instr_i[26]);
      // R7: register jumps land on the register value
      p_regjump_r7: assert (!jreg || (taken_o && next_pc_o == rs_val_i));
      // R6 R8: a link write carries PC+4 and comes with a taken jump
      p_link_r8: assert (!link_we_o || (taken_o && link_val_o == pc_i + XLEN'(4)));
    end
  end
endmodule

bind bjn_unit bjn_unit_chk #(.XLEN(XLEN)) u_chk (
  .pc_i       (pc_i),
  .instr_i    (instr_i),
  .rs_val_i   (rs_val_i),
  .next_pc_o  (next_pc_o),
  .taken_o    (taken_o),
  .link_we_o  (link_we_o),
  .link_val_o (link_val_o),
  .br         (cls.br),
  .jrel       (cls.jrel),
  .jreg       (cls.jreg),
  .is_zero    (is_zero),
  .cond_met   (cond_met)
);

// File: tb/sim_bjn_unit.sv
`timescale 1ns/1ps
module sim_bjn_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [31:0] pc, instr, rs;
  logic [31:0] next_pc, link_val;
  logic        taken, link_we;

  bjn_unit u0 (
    .pc_i       (pc),
    .instr_i    (instr),
    .rs_val_i   (rs),
    .next_pc_o  (next_pc),
    .taken_o    (taken),
    .link_we_o  (link_we),
    .link_val_o (link_val)
  );

  typedef struct {
    logic [31:0] npc;
    logic        tk;
    logic        lw;
    logic [31:0] lv;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic exp_t model(input logic [31:0] p, input logic [31:0] w,
                                 input logic [31:0] r, input string tag);
    exp_t e;
    longint seq, off;
    seq = longint'(p) + 4;
    e.npc = 32'(seq);
    e.tk = 0; e.lw = 0; e.lv = 32'(seq); e.tag = tag;
    case (w[31:26])
      6'd16: if (r == 0) begin off = longint'($signed(w[15:0])); e.npc = 32'(seq + off); e.tk = 1; end
      6'd17: if (r != 0) begin off = longint'($signed(w[15:0])); e.npc = 32'(seq + off); e.tk = 1; end
      6'd12, 6'd13: begin
        off = longint'($signed(w[25:0])); e.npc = 32'(seq + off); e.tk = 1; e.lw = (w[31:26] == 6'd13);
      end
      6'd14, 6'd15: begin e.npc = r; e.tk = 1; e.lw = (w[31:26] == 6'd15); end
      default: ;
    endcase
    if (!e.lw) e.lv = 32'(seq);
    return e;
  endfunction

  task automatic apply(input logic [31:0] p, input logic [5:0] op,
                       input logic [25:0] body, input logic [31:0] r, input string tag);
    @(posedge clk);
    #1;
    pc = p; instr = {op, body}; rs = r;
    q.push_back(model(p, {op, body}, r, tag));
  endtask

  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (next_pc !== e.npc || taken !== e.tk || link_we !== e.lw ||
          (e.lw && link_val !== e.lv)) begin
        errors++;
        $display("FAIL %s: got npc=%h tk=%b lw=%b lv=%h exp npc=%h tk=%b lw=%b lv=%h",
                 e.tag, next_pc, taken, link_we, link_val, e.npc, e.tk, e.lw, e.lv);
      end
    end
  end

  initial begin
    pc = 0; instr = 0; rs = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1: reset-time all-zero inputs and non-control opcodes
    q.push_back(model(0, 0, 0, "R1 reset zero word"));
    apply(32'h0000_1000, 6'b000000, 26'h0443_020, 32'h0, "R1 register alu word");
    apply(32'h0000_2000, 6'b010010, 26'h000_0010, 32'h0, "R1 near branch opcode");
    apply(32'h0000_3000, 6'b001011, 26'h000_0040, 32'h5, "R1 near jump opcode");
    apply(32'h0000_3000, 6'b110000, 26'h3FF_FFFF, 32'h0, "R1 upper opcode");
    // R2 / R3: branch on zero
    apply(32'h0000_1000, 6'b010000, {10'h3A5, 16'h0040}, 32'h0, "R2 forward taken");
    apply(32'h0000_1000, 6'b010000, {10'h000, 16'h8000}, 32'h0, "R2 R9 min offset wrap");
    apply(32'h0000_1000, 6'b010000, {10'h000, 16'h0040}, 32'h1, "R3 nonzero reg");
    apply(32'h0000_1000, 6'b010000, {10'h000, 16'hFFF0}, 32'h8000_0000, "R3 sign bit reg");
    // R4: branch on nonzero
    apply(32'h0000_4000, 6'b010001, {10'h000, 16'hFF00}, 32'h7, "R4 backward taken");
    apply(32'h0000_4000, 6'b010001, {10'h000, 16'h8000}, 32'hFFFF_FFFF, "R4 R9 min offset");
    apply(32'h0000_4000, 6'b010001, {10'h000, 16'h0100}, 32'h0, "R4 zero reg");
    // R5 / R6: relative jumps
    apply(32'h0000_0100, 6'b001100, 26'h000_1000, 32'h0, "R5 forward jump");
    apply(32'h0400_0000, 6'b001100, 26'h200_0000, 32'h0, "R5 R9 min 26-bit offset");
    apply(32'h0000_0100, 6'b001100, 26'h3FF_FFF8, 32'h0, "R5 backward jump");
    apply(32'h0000_0200, 6'b001101, 26'h000_0200, 32'h0, "R6 jump with link");
    apply(32'h0800_0000, 6'b001101, 26'h200_0000, 32'hABCD, "R6 R9 min offset link");
    // R7 / R8: register jumps
    apply(32'h0000_0300, 6'b001110, 26'h0, 32'hDEAD_BEE0, "R7 register jump");
    apply(32'h0000_0400, 6'b001111, 26'h0, 32'h0000_1234, "R8 register jump link");
    apply(32'hFFFF_FFFC, 6'b001111, 26'h0, 32'h0, "R8 R9 link wraps to zero");
    // R9: sequential wrap and small negative branch below zero
    apply(32'hFFFF_FFFC, 6'b000000, 26'h0, 32'h0, "R9 sequential wrap");
    apply(32'h0000_0000, 6'b010000, {10'h000, 16'hFFF4}, 32'h0, "R9 branch below zero");
    apply(32'h0000_0000, 6'b010000, {10'h000, 16'h0003}, 32'h0, "R9 unscaled odd offset");
    @(posedge clk);
    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule